// File: doc/BRIEF.md
# Memory-Card Host Status Register

This block is the status register of a memory-card host controller. It takes single-cycle event pulses from the command path, the data path and the SDIO interrupt logic, and level inputs from the DMA engine and the read-wait logic. It presents all of them as one 32-bit word on a CPU read port. It also drives one interrupt line, which is the OR of the status bits that an interrupt-mask register enables.

Each status bit follows one of three clearing rules:

- Data-path and SDIO events are sticky and clear on the cycle after a status read.
- Response errors are sticky and clear only when software writes the command register.
- DMA and read-wait bits follow their inputs live and are never latched.

A read returns the word as it stood before any clear. An event that arrives in the same cycle as its clear keeps its bit set, so no event is lost.

Top module: `sdhost_status_reg`

## Requirements
- R1: While reset is held, and on the first cycle after it, `statusData` is zero and `irqOut` is low.
- R2: A pulse on `dataEvt` bit i sets status bit 8+i on the next cycle, and the bit then stays set. The bit order is: bit 8 completion-signal timeout, 9 data timeout, 10 data CRC error, 11 completion signal received.
- R3: In the cycle where `statusRd` is high, `statusData` shows the value before the clear. From the next cycle, bits 8..13 are zero unless a new event arrived.
- R4: A pulse on `respEvt` bit i sets status bit 16+i, and the bit stays set. The bit order is: 16 response timeout, 17 missing end bit, 18 wrong direction bit, 19 CRC7 error, 20 index mismatch. A status read does not clear these bits. A `cmdWr` pulse clears them from the next cycle.
- R5: A `cmdWr` pulse has no effect on bits 8..13.
- R6: An event pulse in the same cycle as the clearing strobe for its bit leaves that bit set on the next cycle.
- R7: Bits 0..3 show `dmaLvl` in the same cycle, with no latching. The bit order is: 0 TX buffer empty, 1 RX buffer full, 2 transmit finished, 3 receive finished.
- R8: Bit 4 shows `readWaitLvl` in the same cycle.
- R9: Bits 5..7, 14..15 and 21..31 always read as zero.
- R10: A `maskWr` pulse loads `maskData` into the mask. `irqOut` is high exactly when some status bit and its mask bit are both set. A newly loaded mask takes effect on the cycle after the write.
- R11: The SDIO interrupts of slot A and slot B are separate sticky bits, at 12 and 13. They are fed by `dataEvt` bits 4 and 5 and follow R2, R3 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statusRd | input | 1 | CPU read strobe for the status register |
| cmdWr | input | 1 | Strobe for a write to the command register |
| maskWr | input | 1 | Strobe for a write to the interrupt mask |
| maskData | input | 32 | Value to load into the mask |
| dataEvt | input | 6 | Pulses for the events cleared on read |
| respEvt | input | 5 | Pulses for the response errors |
| dmaLvl | input | 4 | Live DMA condition levels |
| readWaitLvl | input | 1 | High while the data bus is in read-wait |
| statusData | output | 32 | Status word |
| irqOut | output | 1 | Masked interrupt line |

## Verification
Level bits reach `statusData` in the same cycle they are driven. Sticky bits appear one clock edge after their pulse. Clears show one edge after the strobe, and a newly written mask acts on `irqOut` one edge after the write. The bench drives every input just after a falling edge and samples 3 ns later, before the next rising edge. Each expected value therefore counts the edges that have passed since the stimulus. The vector table checks the word in the stimulus cycle itself. Coincident event-and-clear cases and mask timing are checked one cycle after their stimulus.

// File: rtl/sdhost_status_pkg.sv
package sdhost_status_pkg;
  localparam int DMA_N    = 4;
  localparam int DATA_N   = 6;
  localparam int RESP_N   = 5;
  localparam int DMA_BASE = 0;
  localparam int WAIT_POS = 4;
  localparam int DATA_BASE = 8;
  localparam int RESP_BASE = 16;
  localparam int TOP_BIT  = RESP_BASE + RESP_N - 1;

  typedef struct packed {
    logic clrRead;
    logic clrCmd;
    logic loadMask;
  } strobe_t;
endpackage

// File: rtl/sdhost_status_ctrl.sv
module sdhost_status_ctrl
  import sdhost_status_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    statusRd,
  input  logic    cmdWr,
  input  logic    maskWr,
  output strobe_t strb
);
  always_comb begin
    strb.clrRead  = rstN & statusRd;
    strb.clrCmd   = rstN & cmdWr;
    strb.loadMask = rstN & maskWr;
  end

  assert_strobeReset_R1: assert property (@(posedge clk)
    !rstN |-> (strb == '0));
endmodule

// File: rtl/sdhost_status_dp.sv
module sdhost_status_dp
  import sdhost_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] maskData,
  input  logic [DATA_N-1:0] dataEvt,
  input  logic [RESP_N-1:0] respEvt,
  input  logic [DMA_N-1:0]  dmaLvl,
  input  logic              readWaitLvl,
  output logic [DATA_W-1:0] statusData,
  output logic              irqOut
);
  logic [DATA_N-1:0] dataQ;
  logic [RESP_N-1:0] respQ;
  logic [DATA_W-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      respQ <= '0;
      maskQ <= '0;
    end else begin
      dataQ <= (dataQ & ~{DATA_N{strb.clrRead}}) | dataEvt;
      respQ <= (respQ & ~{RESP_N{strb.clrCmd}}) | respEvt;
      if (strb.loadMask) maskQ <= maskData;
    end
  end

  always_comb begin
    statusData = '0;
    for (int i = 0; i < DMA_N; i++) statusData[DMA_BASE + i] = dmaLvl[i];
    statusData[WAIT_POS] = readWaitLvl;
    for (int i = 0; i < DATA_N; i++) statusData[DATA_BASE + i] = dataQ[i];
    for (int i = 0; i < RESP_N; i++) statusData[RESP_BASE + i] = respQ[i];
  end

  assign irqOut = |(statusData & maskQ);

  assert_readClear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrRead |=> (dataQ == $past(dataEvt)));
  assert_cmdClear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCmd |=> (respQ == $past(respEvt)));
  assert_respHold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrCmd |=> ((respQ & $past(respQ)) == $past(respQ)));
  assert_dataHold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrRead |=> ((dataQ & $past(dataQ)) == $past(dataQ)));
  assert_eventKept_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((dataQ & $past(dataEvt)) == $past(dataEvt)) &&
              ((respQ & $past(respEvt)) == $past(respEvt))));
endmodule

// File: rtl/sdhost_status_reg.sv
module sdhost_status_reg
  import sdhost_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              statusRd,
  input  logic              cmdWr,
  input  logic              maskWr,
  input  logic [DATA_W-1:0] maskData,
  input  logic [DATA_N-1:0] dataEvt,
  input  logic [RESP_N-1:0] respEvt,
  input  logic [DMA_N-1:0]  dmaLvl,
  input  logic              readWaitLvl,
  output logic [DATA_W-1:0] statusData,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] USED_MAP =
    DATA_W'(((1 << DMA_N) - 1) << DMA_BASE) |
    DATA_W'(1 << WAIT_POS) |
    DATA_W'(((1 << DATA_N) - 1) << DATA_BASE) |
    DATA_W'(((1 << RESP_N) - 1) << RESP_BASE);

  strobe_t strb;

  sdhost_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .cmdWr(cmdWr),
    .maskWr(maskWr), .strb(strb)
  );

  sdhost_status_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .maskData(maskData),
    .dataEvt(dataEvt), .respEvt(respEvt), .dmaLvl(dmaLvl),
    .readWaitLvl(readWaitLvl), .statusData(statusData), .irqOut(irqOut)
  );

  assert_unusedZero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusData & ~USED_MAP) == '0);
  assert_liveDma_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusData[DMA_BASE +: DMA_N] == dmaLvl) && (statusData[WAIT_POS] == readWaitLvl));
  assert_irqNeedsStatus_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusData != '0));
endmodule

// File: tb/sdhost_status_reg_tb.sv
module sdhost_status_reg_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        statusRd = 1'b0, cmdWr = 1'b0, maskWr = 1'b0;
  logic [31:0] maskData = '0;
  logic [5:0]  dataEvt = '0;
  logic [4:0]  respEvt = '0;
  logic [3:0]  dmaLvl = '0;
  logic        readWaitLvl = 1'b0;
  logic [31:0] statusData;
  logic        irqOut;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sdhost_status_reg u_dut (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .cmdWr(cmdWr), .maskWr(maskWr),
    .maskData(maskData), .dataEvt(dataEvt), .respEvt(respEvt), .dmaLvl(dmaLvl),
    .readWaitLvl(readWaitLvl), .statusData(statusData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [5:0]  dEvt;
    logic [4:0]  rEvt;
    logic        rd;
    logic        cmd;
    logic [3:0]  dma;
    logic        rw;
    logic [31:0] exp;
  } vec_t;

  // expected word is sampled in the same cycle the row is driven
  localparam vec_t VECS [12] = '{
    '{6'b000001, 5'b00000, 1'b0, 1'b0, 4'b0000, 1'b0, 32'h0000_0000},
    '{6'b000000, 5'b00001, 1'b0, 1'b0, 4'b0101, 1'b0, 32'h0000_0105},
    '{6'b000000, 5'b00000, 1'b1, 1'b0, 4'b0000, 1'b0, 32'h0001_0100},
    '{6'b100000, 5'b00000, 1'b0, 1'b1, 4'b0000, 1'b0, 32'h0001_0000},
    '{6'b010000, 5'b00000, 1'b0, 1'b0, 4'b0000, 1'b1, 32'h0000_2010},
    '{6'b000100, 5'b00000, 1'b1, 1'b0, 4'b0000, 1'b0, 32'h0000_3000},
    '{6'b000000, 5'b10000, 1'b0, 1'b1, 4'b1010, 1'b0, 32'h0000_040A},
    '{6'b000000, 5'b00000, 1'b0, 1'b0, 4'b0000, 1'b0, 32'h0010_0400},
    '{6'b000000, 5'b00000, 1'b1, 1'b0, 4'b0000, 1'b0, 32'h0010_0400},
    '{6'b000000, 5'b00000, 1'b0, 1'b0, 4'b1111, 1'b1, 32'h0010_001F},
    '{6'b000000, 5'b00000, 1'b0, 1'b1, 4'b0000, 1'b0, 32'h0010_0000},
    '{6'b000000, 5'b00000, 1'b0, 1'b0, 4'b0000, 1'b0, 32'h0000_0000}
  };
  localparam string VTAG [12] = '{
    "R2 before edge", "R2 R7 bit8 set, dma live", "R3 R4 pre-clear value",
    "R3 R5 bit8 cleared", "R8 R11 slot B set, read-wait", "R3 R11 pre-clear A/B",
    "R3 R6 R7 coincident data event kept", "R4 R5 resp kept, bit10 kept",
    "R4 read leaves resp bit", "R3 R7 R8 bit10 cleared, live levels",
    "R4 pre-clear", "R4 cleared by command write"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyIn(input logic [5:0] d, input logic [4:0] r, input logic rd,
                         input logic cmd, input logic [3:0] dma, input logic rw,
                         input logic mw, input logic [31:0] md);
    @(negedge clk);
    dataEvt = d; respEvt = r; statusRd = rd; cmdWr = cmd; dmaLvl = dma;
    readWaitLvl = rw; maskWr = mw; maskData = md;
    #3;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk("R1 status in reset", statusData, 32'h0);
    chk("R1 irq in reset", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #3;
    chk("R1 status after reset", statusData, 32'h0);

    for (int i = 0; i < 12; i++) begin
      applyIn(VECS[i].dEvt, VECS[i].rEvt, VECS[i].rd, VECS[i].cmd,
              VECS[i].dma, VECS[i].rw, 1'b0, 32'h0);
      chk(VTAG[i], statusData, VECS[i].exp);
    end

    // R10 mask timing and masking
    applyIn(6'b000010, 5'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 32'h0000_0200);
    chk("R10 irq low before mask and event land", {31'h0, irqOut}, 32'h0);
    applyIn(6'h0, 5'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0);
    chk("R10 irq from masked data timeout", {31'h0, irqOut}, 32'h1);
    chk("R2 data timeout at bit 9", statusData, 32'h0000_0200);
    applyIn(6'h0, 5'h0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0);
    chk("R3 R10 irq held during read", {31'h0, irqOut}, 32'h1);
    applyIn(6'h0, 5'h0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, 32'h0);
    chk("R10 unmasked rx-full gives no irq", {31'h0, irqOut}, 32'h0);
    applyIn(6'h0, 5'h0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b1, 32'h0000_0002);
    chk("R10 new mask not yet active", {31'h0, irqOut}, 32'h0);
    applyIn(6'h0, 5'h0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, 32'h0);
    chk("R10 new mask active next cycle", {31'h0, irqOut}, 32'h1);
    applyIn(6'h0, 5'h0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 32'h0);
    chk("R7 R10 live level drop lowers irq", {31'h0, irqOut}, 32'h0);

    // R9 all sources high
    applyIn(6'h3F, 5'h1F, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0, 32'h0);
    applyIn(6'h0, 5'h0, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0, 32'h0);
    chk("R9 R11 full map", statusData, 32'h001F_3F1F);
    chk("R9 unused bits zero", statusData & ~32'h001F_3F1F, 32'h0);
    applyIn(6'h0, 5'h0, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 32'h0);
    applyIn(6'h0, 5'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 32'h0);
    chk("R5 R4 cmd write clears only response bits", statusData, 32'h0000_3F00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule